// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD registers: seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. A one-cycle enable pulse, normally once per second, advances the chain. Carries ripple through every field in the same cycle as the pulse. The counter handles month lengths and handles leap years for years 00 to 99.

The top bit of the seconds register is a run/stop flag. While it is set, the whole chain holds its value. A host register file can overwrite any single register in one cycle. A write takes precedence over a pulse that arrives in the same cycle. The block does not repair out-of-range values written by the host.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the registers read seconds 00, minutes 00, hours 00, day of week DOW_FIRST (01), date 01, month 01 and year 00, with the stop flag clear.
- R2: Each tick while running adds one to the seconds count in packed BCD, so the low digit rolls from 9 to 0 and the tens digit increments (09 becomes 10). Bits 6:0 of the seconds byte hold the count.
- R3: Register select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. A write with a valid code shows the written byte on that register's output in the next cycle.
- R4: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. The whole carry completes on the same tick.
- R5: At 23:59:59 a tick gives 00:00:00, advances the date and advances the day of week.
- R6: The day of week counts up by one at each midnight and wraps from DOW_LAST (07) to DOW_FIRST (01).
- R7: The date wraps to 01 and the month advances after day 30 of months 04, 06, 09 and 11, and after day 31 of every other month except February.
- R8: February ends after day 29 when the year is a multiple of four, including year 00, and after day 28 otherwise.
- R9: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R10: While bit 7 of the seconds byte is 1, ticks change no register.
- R11: When a write and a tick fall in the same cycle, the write is stored and the tick is dropped, so no other register moves.
- R12: In cycles with neither a tick nor a write, all registers hold.
- R13: A write with select code 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Once-per-second advance enable |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 3 | Register select code for the write |
| wr_data_i | input | 8 | Packed-BCD byte to write |
| sec_o | output | 8 | Bit 7 stop flag, bits 6:0 seconds BCD |
| min_o | output | 8 | Minutes BCD |
| hour_o | output | 8 | Hours BCD, 00 to 23 |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month BCD |
| month_o | output | 8 | Month BCD |
| year_o | output | 8 | Year BCD |

## Verification
The bench builds the block with its default parameters, a day-of-week range of 01 to 07. With that range the 07 to 01 wrap occurs on one midnight once the register has been preloaded. Register writes put the counter directly at each boundary: end of minute, end of hour, midnight, every month length, leap and non-leap Februaries including year 00 and odd tens digits, and end of year. As a result, each rollover needs only one tick, and no long run of counting is needed to reach it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int BCD_W = 8;
    localparam int NREG  = 7;

    localparam int SEL_SEC   = 0;
    localparam int SEL_MIN   = 1;
    localparam int SEL_HOUR  = 2;
    localparam int SEL_WDAY  = 3;
    localparam int SEL_DATE  = 4;
    localparam int SEL_MONTH = 5;
    localparam int SEL_YEAR  = 6;

    typedef struct packed {
        logic [NREG-1:0][BCD_W-1:0] r;
    } cal_state_t;
endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
    parameter int W = 8
) (
    input  logic         en_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    logic at_top;

    always_comb begin
        at_top = (cur_i >= hi_i);
        wrap_o = en_i & at_top;
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (at_top) begin
            nxt_o = lo_i;
        end else if (cur_i[3:0] >= 4'd9) begin
            nxt_o = cur_i;
            nxt_o[3:0] = 4'd0;
            nxt_o[7:4] = cur_i[7:4] + 4'd1;
        end else begin
            nxt_o = cur_i + W'(1);
        end
    end
endmodule

// File: rtl/month_days.sv
module month_days #(
    parameter int W = 8
) (
    input  logic [W-1:0] month_i,
    input  logic [W-1:0] year_i,
    output logic [W-1:0] last_day_o
);
    logic [1:0] mod4;
    logic       leap;

    always_comb begin
        // tens*10 + ones is a multiple of 4 exactly when 2*tens + ones is
        mod4 = {year_i[4], 1'b0} + year_i[1:0];
        leap = (mod4 == 2'd0);
        unique case (month_i)
            W'(8'h02):                                  last_day_o = leap ? W'(8'h29) : W'(8'h28);
            W'(8'h04), W'(8'h06), W'(8'h09), W'(8'h11): last_day_o = W'(8'h30);
            default:                                    last_day_o = W'(8'h31);
        endcase
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] DOW_FIRST = 8'h01,
    parameter logic [7:0] DOW_LAST  = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    cal_state_t st_d, st_q;

    logic                 halt_q;
    logic                 run_d;
    logic                 sel_ok;
    logic [BCD_W-1:0]     mlen_d;
    logic [NREG-1:0]      en_d;
    logic [NREG-1:0]      wrap_d;
    logic [BCD_W-1:0]     lo_d   [NREG];
    logic [BCD_W-1:0]     hi_d   [NREG];
    logic [BCD_W-1:0]     cur_d  [NREG];
    logic [BCD_W-1:0]     nxt_d  [NREG];

    assign halt_q = st_q.r[SEL_SEC][7];
    assign sel_ok = (int'(wr_sel_i) < NREG);
    assign run_d  = tick_i & ~wr_en_i & ~halt_q;

    month_days #(.W(BCD_W)) u_mdays (
        .month_i    (st_q.r[SEL_MONTH]),
        .year_i     (st_q.r[SEL_YEAR]),
        .last_day_o (mlen_d)
    );

    // carry chain: day of week and date both advance on the hour wrap
    assign en_d[SEL_SEC]   = run_d;
    assign en_d[SEL_MIN]   = wrap_d[SEL_SEC];
    assign en_d[SEL_HOUR]  = wrap_d[SEL_MIN];
    assign en_d[SEL_WDAY]  = wrap_d[SEL_HOUR];
    assign en_d[SEL_DATE]  = wrap_d[SEL_HOUR];
    assign en_d[SEL_MONTH] = wrap_d[SEL_DATE];
    assign en_d[SEL_YEAR]  = wrap_d[SEL_MONTH];

    always_comb begin
        lo_d[SEL_SEC]   = 8'h00;  hi_d[SEL_SEC]   = 8'h59;
        lo_d[SEL_MIN]   = 8'h00;  hi_d[SEL_MIN]   = 8'h59;
        lo_d[SEL_HOUR]  = 8'h00;  hi_d[SEL_HOUR]  = 8'h23;
        lo_d[SEL_WDAY]  = DOW_FIRST; hi_d[SEL_WDAY] = DOW_LAST;
        lo_d[SEL_DATE]  = 8'h01;  hi_d[SEL_DATE]  = mlen_d;
        lo_d[SEL_MONTH] = 8'h01;  hi_d[SEL_MONTH] = 8'h12;
        lo_d[SEL_YEAR]  = 8'h00;  hi_d[SEL_YEAR]  = 8'h99;
        for (int i = 0; i < NREG; i++) begin
            cur_d[i] = st_q.r[i];
        end
        cur_d[SEL_SEC][7] = 1'b0;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_step
        bcd_step #(.W(BCD_W)) u_step (
            .en_i   (en_d[g]),
            .cur_i  (cur_d[g]),
            .lo_i   (lo_d[g]),
            .hi_i   (hi_d[g]),
            .nxt_o  (nxt_d[g]),
            .wrap_o (wrap_d[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (sel_ok) begin
                st_d.r[wr_sel_i] = wr_data_i;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                st_d.r[i] = nxt_d[i];
            end
            st_d.r[SEL_SEC][7] = halt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.r[SEL_WDAY]  <= DOW_FIRST;
            st_q.r[SEL_DATE]  <= 8'h01;
            st_q.r[SEL_MONTH] <= 8'h01;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o   = st_q.r[SEL_SEC];
    assign min_o   = st_q.r[SEL_MIN];
    assign hour_o  = st_q.r[SEL_HOUR];
    assign wday_o  = st_q.r[SEL_WDAY];
    assign date_o  = st_q.r[SEL_DATE];
    assign month_o = st_q.r[SEL_MONTH];
    assign year_o  = st_q.r[SEL_YEAR];

    for (genvar a = 0; a < NREG; a++) begin : g_ast_load
        AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && int'(wr_sel_i) == a) |=> st_q.r[a] == $past(wr_data_i)); // R3
    end

    AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && tick_i && wr_sel_i != 3'(SEL_SEC)) |=> $stable(st_q.r[SEL_SEC])); // R11

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && halt_q) |=> $stable(st_q)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !tick_i) |=> $stable(st_q)); // R12

    AST_BAD_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !sel_ok) |=> $stable(st_q)); // R13

    AST_MIN_NO_EARLY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_d && st_q.r[SEL_SEC][6:0] < 7'h59) |=> $stable(st_q.r[SEL_MIN])); // R4

    AST_MIDNIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_d && st_q.r[SEL_SEC] == 8'h59 && st_q.r[SEL_MIN] == 8'h59 && st_q.r[SEL_HOUR] == 8'h23)
        |=> (st_q.r[SEL_HOUR] == 8'h00 && st_q.r[SEL_MIN] == 8'h00 && st_q.r[SEL_SEC] == 8'h00)); // R5
endmodule

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
    localparam logic [7:0] DOW_FIRST = 8'h01;
    localparam logic [7:0] DOW_LAST  = 8'h07;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m [7];
    logic [55:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    rtc_bcd_calendar #(.DOW_FIRST(DOW_FIRST), .DOW_LAST(DOW_LAST)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [55:0] actual();
        return {year_o, month_o, date_o, wday_o, hour_o, min_o, sec_o};
    endfunction

    function automatic logic [55:0] model();
        return {m[6], m[5], m[4], m[3], m[2], m[1], m[0]};
    endfunction

    task automatic model_tick();
        int s, mi, h, d, mo, y, last;
        if (m[0][7]) return;
        s = b2i({1'b0, m[0][6:0]}) + 1;
        mi = b2i(m[1]); h = b2i(m[2]); d = b2i(m[4]); mo = b2i(m[5]); y = b2i(m[6]);
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0;
                    m[3] = (m[3] == DOW_LAST) ? DOW_FIRST : m[3] + 8'd1;
                    if (mo == 2) last = (y % 4 == 0) ? 29 : 28;
                    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) last = 30;
                    else last = 31;
                    d++;
                    if (d > last) begin
                        d = 1; mo++;
                        if (mo > 12) begin
                            mo = 1; y = (y + 1) % 100;
                        end
                    end
                end
            end
        end
        m[0] = i2b(s); m[1] = i2b(mi); m[2] = i2b(h);
        m[4] = i2b(d); m[5] = i2b(mo); m[6] = i2b(y);
    endtask

    // driver: apply one cycle of stimulus and queue the expected registers
    task automatic op(input bit t, input bit w, input logic [2:0] s,
                      input logic [7:0] d, input string tag);
        @(negedge clk);
        tick_i = t; wr_en_i = w; wr_sel_i = s; wr_data_i = d;
        @(posedge clk);
        #1;
        if (w) begin
            if (s < 3'd7) m[s] = d;
        end else if (t) begin
            model_tick();
        end
        exp_q.push_back(model());
        tag_q.push_back(tag);
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y);
        op(0, 1, 3'd0, s,  "R3");
        op(0, 1, 3'd1, mi, "R3");
        op(0, 1, 3'd2, h,  "R3");
        op(0, 1, 3'd3, wd, "R3");
        op(0, 1, 3'd4, d,  "R3");
        op(0, 1, 3'd5, mo, "R3");
        op(0, 1, 3'd6, y,  "R3");
    endtask

    task automatic midnight(input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input string tag);
        set_all(8'h59, 8'h59, 8'h23, wd, d, mo, y);
        op(1, 0, 3'd0, 8'h00, tag);
    endtask

    // monitor: compare queued expectations once the outputs have settled
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [55:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (actual() !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", tg, actual(), e);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = DOW_FIRST;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (actual() !== model()) begin
            errors++;
            $display("FAIL R1: actual %h expected %h", actual(), model());
        end

        op(1, 0, 3'd0, 8'h00, "R2");
        set_all(8'h09, 8'h00, 8'h00, 8'h02, 8'h10, 8'h03, 8'h20);
        op(1, 0, 3'd0, 8'h00, "R2 digit carry");
        for (int i = 0; i < 70; i++) op(1, 0, 3'd0, 8'h00, "R2 run");
        op(0, 0, 3'd0, 8'h00, "R12");
        op(0, 0, 3'd5, 8'h77, "R12");

        set_all(8'h59, 8'h10, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20);
        op(1, 0, 3'd0, 8'h00, "R4 minute");
        set_all(8'h59, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20);
        op(1, 0, 3'd0, 8'h00, "R4 hour");

        midnight(8'h03, 8'h15, 8'h06, 8'h21, "R5");
        midnight(8'h07, 8'h15, 8'h06, 8'h21, "R6");

        midnight(8'h01, 8'h30, 8'h04, 8'h21, "R7 30-day");
        midnight(8'h01, 8'h30, 8'h11, 8'h21, "R7 30-day");
        midnight(8'h01, 8'h30, 8'h01, 8'h21, "R7 31-day");
        midnight(8'h01, 8'h31, 8'h01, 8'h21, "R7 31-day");
        midnight(8'h01, 8'h31, 8'h07, 8'h21, "R7 31-day");

        midnight(8'h01, 8'h28, 8'h02, 8'h23, "R8 non-leap");
        midnight(8'h01, 8'h28, 8'h02, 8'h24, "R8 leap");
        midnight(8'h01, 8'h29, 8'h02, 8'h24, "R8 leap end");
        midnight(8'h01, 8'h28, 8'h02, 8'h00, "R8 year 00");
        midnight(8'h01, 8'h28, 8'h02, 8'h10, "R8 year 10");
        midnight(8'h01, 8'h28, 8'h02, 8'h12, "R8 year 12");

        midnight(8'h01, 8'h31, 8'h12, 8'h45, "R9");
        midnight(8'h01, 8'h31, 8'h12, 8'h99, "R9 year wrap");

        set_all(8'hB0, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h20);
        op(1, 0, 3'd0, 8'h00, "R10 stopped");
        op(1, 0, 3'd0, 8'h00, "R10 stopped");
        op(0, 1, 3'd0, 8'h30, "R3");
        op(1, 0, 3'd0, 8'h00, "R10 resumed");

        set_all(8'h10, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h20);
        op(1, 1, 3'd1, 8'h45, "R11 write wins");
        op(1, 1, 3'd0, 8'h59, "R11 write wins");

        op(0, 1, 3'd7, 8'h55, "R13");
        op(0, 0, 3'd0, 8'h00, "R13 after");

        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule